// File: doc/BRIEF.md
# Configurable Reset Source Controller

This block collects reset requests from four on-chip sources: an external reset pin, a brownout detector and two watchdog timers. A software-writable routing register holds a 2-bit action code for each source. The code decides whether a request ends in a light system reset or in a simulated power-on sequence. The block answers an accepted request with exactly one single-cycle pulse on either the system-reset output or the simulated-POR output. It also records in a cause register which sources made the request. Reloading other registers and running boot code happen downstream and are started by the simulated-POR pulse.

Only the true power-on reset input clears the routing register. System resets and simulated PORs leave it as programmed. After a pulse the controller stays busy and ignores further requests until the reset sequencer downstream reports completion. When brownout is set up to interrupt rather than reset, brownout requests skip the routing and produce an interrupt pulse.

Top module: `rst_route_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), the routing register reads 0x00FFFFFF, the cause register reads 0x00000001, and neither reset output pulses.
- R2: The routing register sits at `reg_sel`=0. Action codes are at bits 1:0 (external pin), 3:2 (brownout), 5:4 (watchdog 0) and 7:6 (watchdog 1). Bits 23:8 read as one and bits 31:24 read as zero. Only bits 7:0 can be written.
- R3: An accepted request from a source whose code is 2'b10 gives a one-cycle `sys_rst_pulse` in the cycle after the request is sampled.
- R4: An accepted request from a source whose code is 2'b11, 2'b00 or 2'b01 gives a one-cycle `sim_por_pulse` in the cycle after the request is sampled.
- R5: A write to the routing register applies in the same cycle it is presented. A request sampled together with the write uses the new code.
- R6: The routing register keeps its value across system resets and simulated PORs. Only `por_n` restores it.
- R7: The cause register is at `reg_sel`=1 and is read-only. On an accepted request it is replaced by the set of requesting sources: bit 1 external pin, bit 2 brownout, bit 3 watchdog 0, bit 4 watchdog 1. Bit 0 (power-on) is cleared.
- R8: A true power-on reset sets cause bit 0 and clears all other cause bits.
- R9: While `bo_irq_mode` is high, a brownout request ignores its code, causes no reset and no cause update, and gives `bo_irq_pulse` high in the following cycle.
- R10: When several sources request in one cycle and any of them selects a simulated POR, only `sim_por_pulse` fires. Every requesting source gets its cause bit.
- R11: After a pulse, requests are ignored and the cause register is left alone until `rst_done` is sampled high. Each reset pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | True power-on reset, asynchronous, active low |
| reg_sel | input | 1 | Register select: 0 routing, 1 cause |
| reg_we | input | 1 | Write strobe for the routing register |
| reg_wdata | input | 8 | Write data for the four action codes |
| reg_rdata | output | 32 | Read data of the selected register |
| src_req | input | 4 | Reset requests: bit 0 pin, 1 brownout, 2 watchdog 0, 3 watchdog 1 |
| bo_irq_mode | input | 1 | Brownout is set up as an interrupt |
| rst_done | input | 1 | Downstream reset sequence finished |
| sys_rst_pulse | output | 1 | System reset request pulse |
| sim_por_pulse | output | 1 | Simulated power-on request pulse |
| bo_irq_pulse | output | 1 | Brownout interrupt request |

## Verification
The bench drives every code value, including the two undocumented ones. A decoder that treats only 2'b11 as a simulated POR would fire the wrong pulse for those codes. A write issued in the same cycle as a request checks that the new code is used; a staged write would route by the old code. Two further cases are a mixed simultaneous request, where a wrong priority fires a system reset, and a request arriving while busy, where a missing busy hold gives a second pulse or overwrites the cause. Brownout is also exercised in interrupt mode with a reset code programmed, so a missing mask shows up as a stray reset.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
    localparam int NSRC     = 4;
    localparam int FW       = 2;
    localparam int CTRL_W   = NSRC * FW;
    localparam int CAUSE_W  = NSRC + 1;
    localparam int DATA_W   = 32;
    localparam int SRC_PIN  = 0;
    localparam int SRC_BO   = 1;
    localparam int SRC_WD0  = 2;
    localparam int SRC_WD1  = 3;

    typedef enum logic [FW-1:0] {
        ACT_DFLT_A = 2'b00,
        ACT_DFLT_B = 2'b01,
        ACT_SYS    = 2'b10,
        ACT_SPOR   = 2'b11
    } act_e;

    localparam logic [CTRL_W-1:0]  CTRL_RST  = '1;
    localparam logic [CAUSE_W-1:0] CAUSE_POR = CAUSE_W'(1);
endpackage

// File: rtl/rrc_ctrl_reg.sv
module rrc_ctrl_reg
    import rrc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q_o,
    output logic [CTRL_W-1:0] ctrl_eff_o
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl = wdata;
        end
        ctrl_eff_o = st_d.ctrl;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.ctrl <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q_o = st_q.ctrl;

    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!por_n)
        !wr_en |=> $stable(ctrl_q_o)); // R6
endmodule

// File: rtl/rrc_route.sv
module rrc_route
    import rrc_pkg::*;
(
    input  logic [NSRC-1:0]   req,
    input  logic [CTRL_W-1:0] ctrl_eff,
    input  logic              bo_irq_mode,
    output logic [NSRC-1:0]   want_sys,
    output logic [NSRC-1:0]   want_spor,
    output logic              irq_req
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic active;
        act_e act;
        if (i == SRC_BO) begin : g_bo
            assign active = req[i] && !bo_irq_mode;
        end else begin : g_plain
            assign active = req[i];
        end
        assign act          = act_e'(ctrl_eff[i*FW +: FW]);
        assign want_sys[i]  = active && (act == ACT_SYS);
        assign want_spor[i] = active && (act != ACT_SYS);
    end

    assign irq_req = req[SRC_BO] && bo_irq_mode;
endmodule

// File: rtl/rrc_seq.sv
module rrc_seq
    import rrc_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic [NSRC-1:0]    want_sys,
    input  logic [NSRC-1:0]    want_spor,
    input  logic               irq_req,
    input  logic               rst_done,
    output logic               sys_o,
    output logic               spor_o,
    output logic               irq_o,
    output logic [CAUSE_W-1:0] cause_o
);
    typedef struct packed {
        logic               busy;
        logic               sys;
        logic               spor;
        logic               irq;
        logic [CAUSE_W-1:0] cause;
    } st_t;

    st_t st_d, st_q;
    logic [NSRC-1:0] any_src;

    always_comb begin
        any_src   = want_sys | want_spor;
        st_d      = st_q;
        st_d.sys  = 1'b0;
        st_d.spor = 1'b0;
        st_d.irq  = irq_req;
        if (st_q.busy) begin
            if (rst_done) begin
                st_d.busy = 1'b0;
            end
        end else if (|any_src) begin
            st_d.busy  = 1'b1;
            st_d.cause = {any_src, 1'b0};
            if (|want_spor) begin
                st_d.spor = 1'b1;
            end else begin
                st_d.sys = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.busy  <= 1'b0;
            st_q.sys   <= 1'b0;
            st_q.spor  <= 1'b0;
            st_q.irq   <= 1'b0;
            st_q.cause <= CAUSE_POR;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_o   = st_q.sys;
    assign spor_o  = st_q.spor;
    assign irq_o   = st_q.irq;
    assign cause_o = st_q.cause;

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!por_n)
        !(sys_o && spor_o)); // R10
    AST_SPOR_WINS: assert property (@(posedge clk) disable iff (!por_n)
        (!st_q.busy && |want_spor) |=> spor_o); // R10
    AST_SYS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        sys_o |=> !sys_o); // R11
    AST_SPOR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        spor_o |=> !spor_o); // R11
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!por_n)
        st_q.busy |=> !(sys_o || spor_o)); // R11
    AST_CAUSE_POR_CLR: assert property (@(posedge clk) disable iff (!por_n)
        (sys_o || spor_o) |-> !cause_o[0]); // R7
endmodule

// File: rtl/rst_route_ctrl.sv
module rst_route_ctrl
    import rrc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [3:0]        src_req,
    input  logic              bo_irq_mode,
    input  logic              rst_done,
    output logic              sys_rst_pulse,
    output logic              sim_por_pulse,
    output logic              bo_irq_pulse
);
    localparam int RSVD_ONES = 16;
    localparam int RSVD_ZERO = DATA_W - CTRL_W - RSVD_ONES;

    logic [CTRL_W-1:0]  ctrl_q, ctrl_eff;
    logic [NSRC-1:0]    want_sys, want_spor;
    logic               irq_req;
    logic [CAUSE_W-1:0] cause;

    rrc_ctrl_reg u_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .wr_en      (reg_we && !reg_sel),
        .wdata      (reg_wdata),
        .ctrl_q_o   (ctrl_q),
        .ctrl_eff_o (ctrl_eff)
    );

    rrc_route u_route (
        .req         (src_req),
        .ctrl_eff    (ctrl_eff),
        .bo_irq_mode (bo_irq_mode),
        .want_sys    (want_sys),
        .want_spor   (want_spor),
        .irq_req     (irq_req)
    );

    rrc_seq u_seq (
        .clk       (clk),
        .por_n     (por_n),
        .want_sys  (want_sys),
        .want_spor (want_spor),
        .irq_req   (irq_req),
        .rst_done  (rst_done),
        .sys_o     (sys_rst_pulse),
        .spor_o    (sim_por_pulse),
        .irq_o     (bo_irq_pulse),
        .cause_o   (cause)
    );

    always_comb begin
        if (reg_sel) begin
            reg_rdata = {{(DATA_W-CAUSE_W){1'b0}}, cause};
        end else begin
            reg_rdata = {{RSVD_ZERO{1'b0}}, {RSVD_ONES{1'b1}}, ctrl_q};
        end
    end

    AST_BO_MASKED: assert property (@(posedge clk) disable iff (!por_n)
        (bo_irq_mode && src_req == 4'b0010) |=> !(sys_rst_pulse || sim_por_pulse)); // R9
endmodule

// File: tb/rst_route_ctrl_test.sv
module rst_route_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  src_req = '0;
    logic        bo_irq_mode = 1'b0;
    logic        rst_done = 1'b0;
    logic        sys_rst_pulse, sim_por_pulse, bo_irq_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];   // 1 = system reset, 2 = simulated POR
    bit prev_pulse = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_route_ctrl uut (
        .clk(clk), .por_n(por_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .bo_irq_mode(bo_irq_mode), .rst_done(rst_done),
        .sys_rst_pulse(sys_rst_pulse), .sim_por_pulse(sim_por_pulse),
        .bo_irq_pulse(bo_irq_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic fire(input logic [3:0] r, input int kind, input bit do_wr, input logic [7:0] wv);
        @(negedge clk);
        src_req = r;
        if (do_wr) begin
            reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = wv;
        end
        if (kind != 0) exp_q.push_back(kind);
        @(negedge clk);
        src_req = '0;
        reg_we  = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        rst_done = 1'b1;
        @(negedge clk);
        rst_done = 1'b0;
    endtask

    // monitor: pops expected pulses from the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (por_n) begin
                if (sys_rst_pulse || sim_por_pulse) begin
                    n_chk++;
                    if (prev_pulse) begin
                        n_fail++;
                        $display("FAIL R11 pulse longer than one cycle actual=1 expected=0");
                    end else if (sys_rst_pulse && sim_por_pulse) begin
                        n_fail++;
                        $display("FAIL R10 both pulses actual=3 expected=one");
                    end else if (exp_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL R11 unexpected pulse actual=%0d expected=none",
                                 sim_por_pulse ? 2 : 1);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        if ((sim_por_pulse ? 2 : 1) != e) begin
                            n_fail++;
                            $display("FAIL R3/R4 pulse kind actual=%0d expected=%0d",
                                     sim_por_pulse ? 2 : 1, e);
                        end
                    end
                end
                prev_pulse = sys_rst_pulse || sim_por_pulse;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 no pulse in reset", {30'b0, sys_rst_pulse, sim_por_pulse}, 32'h0);
        por_n = 1'b1;
        rd(1'b0, v); chk("R1 R2 routing reset value", v, 32'h00FFFFFF);
        rd(1'b1, v); chk("R1 R8 cause after power-on", v, 32'h00000001);

        // default code 11 on the pin -> simulated POR
        fire(4'b0001, 2, 1'b0, 8'h00);
        rd(1'b1, v); chk("R4 R7 cause pin", v, 32'h00000002);
        done_pulse();

        // pin=10 bo=11 wd0=01 wd1=00 ; cause write ignored
        wr(8'h1E);
        @(negedge clk); reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 8'hFF;
        @(negedge clk); reg_we = 1'b0;
        rd(1'b0, v); chk("R2 routing write", v, 32'h00FFFF1E);

        fire(4'b0001, 1, 1'b0, 8'h00);
        rd(1'b1, v); chk("R3 R7 cause pin sys", v, 32'h00000002);
        done_pulse();
        rd(1'b0, v); chk("R6 routing kept after system reset", v, 32'h00FFFF1E);

        fire(4'b0100, 2, 1'b0, 8'h00);
        rd(1'b1, v); chk("R4 R7 code 01 wd0", v, 32'h00000008);
        done_pulse();

        fire(4'b1000, 2, 1'b0, 8'h00);
        rd(1'b1, v); chk("R4 R7 code 00 wd1", v, 32'h00000010);
        done_pulse();
        rd(1'b0, v); chk("R6 routing kept after simulated POR", v, 32'h00FFFF1E);

        fire(4'b0010, 2, 1'b0, 8'h00);
        rd(1'b1, v); chk("R7 cause brownout", v, 32'h00000004);
        done_pulse();

        // brownout in interrupt mode, then with a system-reset code
        bo_irq_mode = 1'b1;
        fire(4'b0010, 0, 1'b0, 8'h00);
        chk("R9 irq pulse", {31'b0, bo_irq_pulse}, 32'h1);
        @(negedge clk);
        chk("R9 irq pulse ends", {31'b0, bo_irq_pulse}, 32'h0);
        rd(1'b1, v); chk("R9 cause untouched", v, 32'h00000004);

        // mixed simultaneous request: pin sys + wd1 spor
        bo_irq_mode = 1'b0;
        fire(4'b1001, 2, 1'b0, 8'h00);
        rd(1'b1, v); chk("R10 cause both", v, 32'h00000012);
        done_pulse();

        // busy: second request ignored
        fire(4'b0001, 1, 1'b0, 8'h00);
        fire(4'b0100, 0, 1'b0, 8'h00);
        repeat (2) @(negedge clk);
        rd(1'b1, v); chk("R11 cause not overwritten while busy", v, 32'h00000002);
        done_pulse();

        // same-cycle write switches pin to 11
        fire(4'b0001, 2, 1'b1, 8'h1F);
        rd(1'b1, v); chk("R5 cause pin", v, 32'h00000002);
        done_pulse();

        // brownout code 10: system reset, and masked in interrupt mode
        wr(8'h1B);
        fire(4'b0010, 1, 1'b0, 8'h00);
        done_pulse();
        bo_irq_mode = 1'b1;
        fire(4'b0010, 0, 1'b0, 8'h00);
        bo_irq_mode = 1'b0;
        repeat (2) @(negedge clk);
        rd(1'b1, v); chk("R9 R3 cause brownout sys", v, 32'h00000004);

        // true power-on restores everything
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd(1'b0, v); chk("R6 R1 routing after power-on", v, 32'h00FFFFFF);
        rd(1'b1, v); chk("R8 cause after power-on", v, 32'h00000001);

        repeat (3) @(negedge clk);
        chk("R11 scoreboard drained", exp_q.size(), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule